// File: doc/BRIEF.md
# Port-Controlled Memory Bank Mapper

This block maps the 64KB view of an 8-bit CPU onto a larger physical store: eight 16KB RAM banks and four 16KB ROM banks. The CPU address is split into four 16KB windows by bits [15:14]. The two middle windows are tied to fixed RAM banks. The top window shows a RAM bank chosen by software. The bottom window shows either one of the ROM banks or RAM bank 0.

Software changes the mapping with I/O writes to two ports. The upper-window port sets the RAM bank for the top window and can also set a lock. The lower-window port selects the ROM bank and chooses between ROM and RAM bank 0 for the bottom window. For every access the block drives a ROM/RAM select, a bank number and an offset within the bank. A memory write that lands in ROM is flagged and does not reach RAM as a write enable.

Top module: `mem_bank_mapper`

## Requirements
- R1: While reset is held and after it is released, window 0 maps to ROM bank 0, window 3 maps to RAM bank 0 and the lock is clear.
- R2: Window 1 (0x4000-0x7FFF) always maps to RAM bank 5 and window 2 (0x8000-0xBFFF) always maps to RAM bank 2, whatever is written to either port.
- R3: An I/O write to 0x7FFD loads data bits [2:0] as the RAM bank for window 3. The new bank applies from the cycle after the write's clock edge.
- R4: An I/O write to 0x1FFD loads data bits [1:0] as the ROM bank for window 0. Data bit 2 set makes window 0 map to RAM bank 0 and clear makes it map to the selected ROM bank. The change applies from the cycle after the write.
- R5: A port write needs io_req_i and wr_i together with an exact 16-bit address match. Any other address, a missing strobe, or a memory-cycle write leaves the mapping unchanged.
- R6: Data bit 5 of a 0x7FFD write sets a lock. The write that sets the lock still loads its own bank. After that, writes to both ports are ignored until the next reset.
- R7: offset_o always equals CPU address bits [13:0].
- R8: A memory write (mem_req_i and wr_i) to a RAM-mapped window raises ram_we_o. A memory write to a ROM-mapped window raises rom_wr_o and leaves ram_we_o low.
- R9: When rom_sel_o is high, bank_o carries the ROM bank number with bit 2 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address, used for both memory and I/O cycles |
| cpu_data_i | input | 8 | CPU write data |
| io_req_i | input | 1 | I/O cycle request |
| mem_req_i | input | 1 | Memory cycle request |
| wr_i | input | 1 | Write strobe |
| rom_sel_o | output | 1 | High when the access targets ROM |
| bank_o | output | 3 | Physical bank number |
| offset_o | output | 14 | Offset within the bank |
| ram_we_o | output | 1 | Write enable forwarded to RAM |
| rom_wr_o | output | 1 | A memory write hit ROM |

## Verification
Two functions meet in one write: loading the top-window bank and setting the lock both come from the same 0x7FFD write. A wrong design might drop the bank while taking the lock. The bench sends that combined write, reads window 3 on the next cycle, and expects the new bank. It then writes to both ports and expects no change. A reference model in the bench, updated on every edge, predicts all outputs on every cycle, including near-miss port addresses and a later reset that must clear the lock.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int OFFS_W     = 14;
  localparam int BANK_W     = 3;
  localparam int ROM_BANK_W = 2;
  localparam int N_WIN      = 1 << (ADDR_W - OFFS_W);

  typedef struct packed {
    logic [BANK_W-1:0]     top_bank;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic                  low_ram;
    logic                  locked;
  } page_cfg_t;
endpackage

// File: rtl/page_port_decode.sv
module page_port_decode
  import bank_map_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h7FFD
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_req_i,
  input  logic              wr_i,
  output logic              hit_o
);
  assign hit_o = io_req_i && wr_i && (addr_i == PORT_ADDR);
endmodule

// File: rtl/page_cfg_regs.sv
module page_cfg_regs
  import bank_map_pkg::*;
#(
  parameter int LOCK_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_top_i,
  input  logic              hit_low_i,
  input  logic [DATA_W-1:0] data_i,
  output page_cfg_t         cfg_o
);
  page_cfg_t cfg_q;
  logic      wr_ok;

  assign wr_ok = !cfg_q.locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_ok) begin
      if (hit_top_i) begin
        cfg_q.top_bank <= data_i[BANK_W-1:0];
        cfg_q.locked   <= data_i[LOCK_BIT];
      end
      if (hit_low_i) begin
        cfg_q.rom_bank <= data_i[ROM_BANK_W-1:0];
        cfg_q.low_ram  <= data_i[ROM_BANK_W];
      end
    end
  end

  assign cfg_o = cfg_q;

  AST_LOCK_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.locked |=> $stable(cfg_q)); // R6
  AST_TOP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_top_i && !cfg_q.locked) |=> cfg_q.top_bank == $past(data_i[BANK_W-1:0])); // R3
  AST_LOW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_low_i && !cfg_q.locked) |=> cfg_q.low_ram == $past(data_i[ROM_BANK_W])); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_top_i && !hit_low_i) |=> $stable(cfg_q)); // R5
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import bank_map_pkg::*;
#(
  parameter int WIN1_BANK = 5,
  parameter int WIN2_BANK = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  page_cfg_t             cfg_i,
  output logic                  rom_sel_o,
  output logic [BANK_W-1:0]     bank_o,
  output logic [OFFS_W-1:0]     offset_o
);
  localparam int WIN_W = ADDR_W - OFFS_W;

  logic [BANK_W-1:0] win_bank [N_WIN];
  logic [N_WIN-1:0]  win_rom;
  logic [WIN_W-1:0]  win;

  assign win = addr_i[ADDR_W-1:OFFS_W];

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    if (w == 0) begin : g_low
      assign win_rom[w]  = !cfg_i.low_ram;
      assign win_bank[w] = cfg_i.low_ram ? '0
                         : {{(BANK_W-ROM_BANK_W){1'b0}}, cfg_i.rom_bank};
    end else if (w == N_WIN-1) begin : g_top
      assign win_rom[w]  = 1'b0;
      assign win_bank[w] = cfg_i.top_bank;
    end else if (w == 1) begin : g_mid1
      assign win_rom[w]  = 1'b0;
      assign win_bank[w] = BANK_W'(WIN1_BANK);
    end else begin : g_mid2
      assign win_rom[w]  = 1'b0;
      assign win_bank[w] = BANK_W'(WIN2_BANK);
    end
  end

  assign rom_sel_o = win_rom[win];
  assign bank_o    = win_bank[win];
  assign offset_o  = addr_i[OFFS_W-1:0];

  AST_MID_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win == 1 || win == 2) |-> !rom_sel_o); // R2
  AST_ROM_BANK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_sel_o |-> !bank_o[BANK_W-1]); // R9
endmodule

// File: rtl/mem_bank_mapper.sv
module mem_bank_mapper
  import bank_map_pkg::*;
#(
  parameter logic [15:0] TOP_PORT  = 16'h7FFD,
  parameter logic [15:0] LOW_PORT  = 16'h1FFD,
  parameter int          LOCK_BIT  = 5,
  parameter int          WIN1_BANK = 5,
  parameter int          WIN2_BANK = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] cpu_addr_i,
  input  logic [7:0]  cpu_data_i,
  input  logic        io_req_i,
  input  logic        mem_req_i,
  input  logic        wr_i,
  output logic        rom_sel_o,
  output logic [2:0]  bank_o,
  output logic [13:0] offset_o,
  output logic        ram_we_o,
  output logic        rom_wr_o
);
  logic      hit_top, hit_low, mem_wr;
  page_cfg_t cfg;

  page_port_decode #(.PORT_ADDR(TOP_PORT)) u_dec_top (
    .addr_i(cpu_addr_i), .io_req_i(io_req_i), .wr_i(wr_i), .hit_o(hit_top));
  page_port_decode #(.PORT_ADDR(LOW_PORT)) u_dec_low (
    .addr_i(cpu_addr_i), .io_req_i(io_req_i), .wr_i(wr_i), .hit_o(hit_low));

  page_cfg_regs #(.LOCK_BIT(LOCK_BIT)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_top_i(hit_top), .hit_low_i(hit_low),
    .data_i(cpu_data_i), .cfg_o(cfg));

  page_xlate #(.WIN1_BANK(WIN1_BANK), .WIN2_BANK(WIN2_BANK)) u_xlate (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(cpu_addr_i), .cfg_i(cfg),
    .rom_sel_o(rom_sel_o), .bank_o(bank_o), .offset_o(offset_o));

  assign mem_wr   = mem_req_i && wr_i;
  assign ram_we_o = mem_wr && !rom_sel_o;
  assign rom_wr_o = mem_wr && rom_sel_o;

  AST_ROM_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_sel_o |-> !ram_we_o); // R8
  AST_WR_ROUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && wr_i) |-> $countones({ram_we_o, rom_wr_o}) == 1); // R8
endmodule

// File: tb/tb_mem_bank_mapper.sv
module tb_mem_bank_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        io = 1'b0, mem = 1'b0, wr = 1'b0;
  logic        rom_sel, ram_we, rom_wr;
  logic [2:0]  bank;
  logic [13:0] offs;

  int n_chk = 0, n_fail = 0;
  int m_top = 0, m_rom = 0, m_ram0 = 0, m_lock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_bank_mapper dut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(addr), .cpu_data_i(data),
    .io_req_i(io), .mem_req_i(mem), .wr_i(wr), .rom_sel_o(rom_sel),
    .bank_o(bank), .offset_o(offs), .ram_we_o(ram_we), .rom_wr_o(rom_wr));

  task automatic compare(input string tag);
    logic        e_rom;
    int          e_bank;
    logic [19:0] got, exp;
    case (addr[15:14])
      2'd0: begin e_rom = (m_ram0 == 0); e_bank = m_ram0 ? 0 : m_rom; end
      2'd1: begin e_rom = 1'b0; e_bank = 5; end
      2'd2: begin e_rom = 1'b0; e_bank = 2; end
      default: begin e_rom = 1'b0; e_bank = m_top; end
    endcase
    exp = {e_rom, 3'(e_bank), addr[13:0], mem & wr & ~e_rom, mem & wr & e_rom};
    got = {rom_sel, bank, offs, ram_we, rom_wr};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, got, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [7:0] d,
                      input logic i, input logic m, input logic w, input string tag);
    @(negedge clk);
    addr = a; data = d; io = i; mem = m; wr = w;
    #2;
    compare(tag);
    @(posedge clk);
    if (rst_ni && i && w && m_lock == 0) begin
      if (a == 16'h7FFD) begin m_top = int'(d[2:0]); m_lock = int'(d[5]); end
      if (a == 16'h1FFD) begin m_rom = int'(d[1:0]); m_ram0 = int'(d[2]); end
    end
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(a, 8'h00, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic iowr(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(a, d, 1'b1, 1'b0, 1'b1, tag);
  endtask

  task automatic show(input logic [15:0] a);
    @(negedge clk);
    addr = a; io = 0; mem = 0; wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state observed while reset is held
    show(16'h0000); #2; compare("R1");
    show(16'hC123); #2; compare("R1");
    @(negedge clk); rst_ni = 1'b1;
    rd(16'h0000, "R1");
    rd(16'hFFFF, "R1");
    // R2 fixed middle windows, R7 offset
    rd(16'h4000, "R2"); rd(16'h7FFF, "R2"); rd(16'h8000, "R2"); rd(16'hBFFF, "R2");
    rd(16'h2ABC, "R7"); rd(16'hD5A5, "R7");
    // R8 write routing
    step(16'h0010, 8'h55, 1'b0, 1'b1, 1'b1, "R8");
    step(16'hC010, 8'h55, 1'b0, 1'b1, 1'b1, "R8");
    step(16'h5000, 8'h55, 1'b0, 1'b1, 1'b1, "R8");
    // R3 every top bank
    for (int b = 0; b < 8; b++) begin
      iowr(16'h7FFD, 8'(b), "R3");
      rd(16'hC000 | 16'(b), "R3");
      rd(16'h4000, "R2");
    end
    // R4 and R9 rom bank and ram-0 select
    for (int b = 0; b < 4; b++) begin
      iowr(16'h1FFD, 8'(b), "R4");
      rd(16'h0100, "R9");
    end
    iowr(16'h1FFD, 8'h04, "R4"); rd(16'h0000, "R4");
    step(16'h0000, 8'hAA, 1'b0, 1'b1, 1'b1, "R8");
    iowr(16'h1FFD, 8'h07, "R4"); rd(16'h3FFF, "R4");
    iowr(16'h1FFD, 8'h03, "R4");
    step(16'h3FFF, 8'hAA, 1'b0, 1'b1, 1'b1, "R8");
    // R5 near misses
    iowr(16'h7FFD, 8'h01, "R5");
    iowr(16'h7FFC, 8'h06, "R5"); rd(16'hC000, "R5");
    iowr(16'hFFFD, 8'h06, "R5"); rd(16'hC000, "R5");
    iowr(16'h1FFE, 8'h04, "R5"); rd(16'h0000, "R5");
    step(16'h7FFD, 8'h06, 1'b1, 1'b0, 1'b0, "R5"); rd(16'hC000, "R5");
    step(16'h7FFD, 8'h26, 1'b0, 1'b1, 1'b1, "R5"); rd(16'hC000, "R5");
    step(16'h1FFD, 8'h04, 1'b0, 1'b1, 1'b1, "R5"); rd(16'h0000, "R5");
    // R6 lock write loads its own bank, then freezes both ports
    iowr(16'h1FFD, 8'h02, "R6");
    iowr(16'h7FFD, 8'h26, "R6");
    rd(16'hC000, "R6");
    iowr(16'h7FFD, 8'h01, "R6"); rd(16'hC000, "R6");
    iowr(16'h1FFD, 8'h05, "R6"); rd(16'h0000, "R6");
    step(16'h0000, 8'h11, 1'b0, 1'b1, 1'b1, "R6");
    // reset clears the lock
    @(negedge clk); rst_ni = 1'b0;
    m_top = 0; m_rom = 0; m_ram0 = 0; m_lock = 0;
    addr = 16'hC000; io = 0; mem = 0; wr = 0; #2; compare("R1");
    @(negedge clk); rst_ni = 1'b1;
    rd(16'h0000, "R1");
    iowr(16'h7FFD, 8'h03, "R6"); rd(16'hC000, "R6");
    iowr(16'h1FFD, 8'h01, "R6"); rd(16'h0000, "R6");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule